// File: doc/BRIEF.md
# Pipelined Three-Stage Clos Multiplexer Fabric

The block is a three-stage Clos switching network built entirely from multiplexers. Each multiplexer output is registered. It has `N1*R1` input ports and `N2*R2` output ports, and every port is `DATA_W` bits wide.

The three stages are built as follows:
- The ingress stage holds `R1` switches of `N1` inputs and `M` outputs.
- The middle stage holds `M` switches of `R1` inputs and `R2` outputs.
- The egress stage holds `R2` switches of `M` inputs and `N2` outputs.

Middle index `t` is kept across the links: output `t` of ingress switch `j` feeds input `j` of middle switch `t`, and output `h` of middle switch `t` feeds input `t` of egress switch `h`.

Routes come from outside the block, from software or from a test environment. They are presented as one flat configuration word. Each multiplexer node has a select field of `max(1, ceil(log2(fan-in)))` bits. Fields are packed with the ingress stage at the least significant end, then the middle stage, then the egress stage. Within a stage the fields are ordered by switch, then by node.

The configuration word travels down the pipeline with the data. A routing change therefore applies to data that enters with it, and data already in flight keeps its old route. `M >= max(N1, N2)` gives rearrangeable unicast. For multicast of fan-out `f`, use `M = f*N1`.

The default instance has these sizes:
- `N1 = R1 = N2 = R2 = 2`, `M = 3` and `DATA_W = 8`.
- The configuration word is 20 bits wide.
- Ingress fields are 1 bit at base 0, middle fields are 1 bit at base 6, and egress fields are 2 bits at base 12.

Top module: `clos_fabric`

## Requirements
- R1: While `rst_ni` is low, and after the first and second rising edges following its release, every output port reads zero.
- R2: A value present on an input port at a rising edge appears on each output routed to it after the third rising edge, counting that edge. This is a latency of 3 cycles.
- R3: The ingress field for switch `j`, node `t` is held in `cfg_i[(j*M+t)*S1_W +: S1_W]`. Its value `s` connects input port `j*N1+s` to middle link `t` of that switch.
- R4: The middle field for switch `t`, output `h` is held in `cfg_i[C1_W + (t*R2+h)*S2_W +: S2_W]`, where `C1_W = R1*M*S1_W`. Its value `j` connects ingress switch `j` to egress switch `h` through middle switch `t`.
- R5: The egress field for switch `h`, output `o` is held in `cfg_i[C1_W + C2_W + (h*N2+o)*S3_W +: S3_W]`, where `C2_W = M*R2*S2_W`. Its value `t` drives output port `h*N2+o` from middle switch `t`. Port `k` occupies bits `[k*DATA_W +: DATA_W]` of its bus.
- R6: A select value at or above the fan-in of its node makes that node register zero.
- R7: One input port can drive several output ports at once (multicast), up to all of them.
- R8: The default instance routes any full permutation of its four inputs onto its four outputs at the same time.
- R9: Each stage uses the configuration that entered with its data. After a change, the two data words already in the pipeline leave on their old routes.
- R10: If the inputs and the configuration hold steady, the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | CFG_W (20) | Packed select fields, ingress fields at the least significant end |
| data_i | input | N1*R1*DATA_W (32) | Input ports, port k at bits [k*DATA_W +: DATA_W] |
| data_o | output | N2*R2*DATA_W (32) | Output ports, registered after the egress stage |

## Verification
The bench steers traffic through deliberately chosen middle switches for three cases:
- A crossing permutation, which a fabric with swapped link indices would misroute.
- A one-to-all multicast, which a fabric that refused shared middle links would drop.
- Egress selects of value 3, which a fabric without a range guard would turn into garbage instead of zero.

It changes the configuration while data is in flight. A fabric that used a live configuration at later stages would switch the output one or two cycles early.

It also counts edges from reset release to the first valid output, which catches an extra or a missing register. A behavioural model then follows several hundred cycles of random configurations and data.

// File: rtl/clos_pkg.sv
package clos_pkg;
  // select width for a node of the given fan-in (at least one bit)
  function automatic int sel_w(int fanin);
    return (fanin > 1) ? $clog2(fanin) : 1;
  endfunction
endpackage

// File: rtl/clos_mux_node.sv
module clos_mux_node #(
  parameter int FANIN  = 2,
  parameter int DATA_W = 8,
  parameter int SEL_W  = clos_pkg::sel_w(FANIN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [FANIN*DATA_W-1:0] data_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [DATA_W-1:0]       data_o
);
  localparam logic [SEL_W:0] FANIN_L = (SEL_W+1)'(FANIN);

  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int k = 0; k < FANIN; k++)
      if (sel_i == SEL_W'(k)) pick = data_i[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) data_o <= '0;
    else         data_o <= pick;

  // R6
  out_of_range_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, sel_i} >= FANIN_L) |=> (data_o == '0));

  // R3
  sel_zero_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |=> (data_o == $past(data_i[DATA_W-1:0])));

  // R10
  stable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(sel_i) && $stable(data_i)) |=> $stable(data_o));
endmodule

// File: rtl/clos_switch.sv
module clos_switch #(
  parameter int IN_N   = 2,
  parameter int OUT_N  = 2,
  parameter int DATA_W = 8,
  parameter int SEL_W  = clos_pkg::sel_w(IN_N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IN_N*DATA_W-1:0]  data_i,
  input  logic [OUT_N*SEL_W-1:0]  sel_i,
  output logic [OUT_N*DATA_W-1:0] data_o
);
  for (genvar o = 0; o < OUT_N; o++) begin : g_node
    clos_mux_node #(.FANIN(IN_N), .DATA_W(DATA_W), .SEL_W(SEL_W)) i_node (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (data_i),
      .sel_i  (sel_i[o*SEL_W +: SEL_W]),
      .data_o (data_o[o*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/clos_fabric.sv
module clos_fabric #(
  parameter int DATA_W = 8,
  parameter int N1     = 2,
  parameter int R1     = 2,
  parameter int M      = 3,
  parameter int N2     = 2,
  parameter int R2     = 2,
  localparam int S1_W  = clos_pkg::sel_w(N1),
  localparam int S2_W  = clos_pkg::sel_w(R1),
  localparam int S3_W  = clos_pkg::sel_w(M),
  localparam int C1_W  = R1*M*S1_W,
  localparam int C2_W  = M*R2*S2_W,
  localparam int C3_W  = R2*N2*S3_W,
  localparam int CFG_W = C1_W + C2_W + C3_W,
  localparam int IN_P  = N1*R1,
  localparam int OUT_P = N2*R2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CFG_W-1:0]        cfg_i,
  input  logic [IN_P*DATA_W-1:0]  data_i,
  output logic [OUT_P*DATA_W-1:0] data_o
);
  // configuration travels with the data
  logic [C2_W-1:0] cfg2_q;
  logic [C3_W-1:0] cfg3_d1_q, cfg3_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg2_q    <= '0;
      cfg3_d1_q <= '0;
      cfg3_q    <= '0;
    end else begin
      cfg2_q    <= cfg_i[C1_W +: C2_W];
      cfg3_d1_q <= cfg_i[C1_W+C2_W +: C3_W];
      cfg3_q    <= cfg3_d1_q;
    end

  logic [M*DATA_W-1:0]  ing_o [R1];
  logic [R1*DATA_W-1:0] mid_i [M];
  logic [R2*DATA_W-1:0] mid_o [M];
  logic [M*DATA_W-1:0]  egr_i [R2];

  for (genvar j = 0; j < R1; j++) begin : g_ing
    clos_switch #(.IN_N(N1), .OUT_N(M), .DATA_W(DATA_W), .SEL_W(S1_W)) i_sw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (data_i[j*N1*DATA_W +: N1*DATA_W]),
      .sel_i  (cfg_i[j*M*S1_W +: M*S1_W]),
      .data_o (ing_o[j])
    );
    for (genvar t = 0; t < M; t++) begin : g_l1
      assign mid_i[t][j*DATA_W +: DATA_W] = ing_o[j][t*DATA_W +: DATA_W];
    end
  end

  for (genvar t = 0; t < M; t++) begin : g_mid
    clos_switch #(.IN_N(R1), .OUT_N(R2), .DATA_W(DATA_W), .SEL_W(S2_W)) i_sw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (mid_i[t]),
      .sel_i  (cfg2_q[t*R2*S2_W +: R2*S2_W]),
      .data_o (mid_o[t])
    );
    for (genvar h = 0; h < R2; h++) begin : g_l2
      assign egr_i[h][t*DATA_W +: DATA_W] = mid_o[t][h*DATA_W +: DATA_W];
    end
  end

  for (genvar h = 0; h < R2; h++) begin : g_egr
    clos_switch #(.IN_N(M), .OUT_N(N2), .DATA_W(DATA_W), .SEL_W(S3_W)) i_sw (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .data_i (egr_i[h]),
      .sel_i  (cfg3_q[h*N2*S3_W +: N2*S3_W]),
      .data_o (data_o[h*N2*DATA_W +: N2*DATA_W])
    );
  end

  // edges since reset, used only by the check below
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;

  // R9
  egress_cfg_age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) |-> (cfg3_q == $past(cfg_i[C1_W+C2_W +: C3_W], 2)));
endmodule

// File: tb/test_clos_fabric.sv
module test_clos_fabric;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cfg = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  int          checks = 0;
  int          errors = 0;
  bit          auto_on = 1'b0;
  string       cur_req = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  clos_fabric i_clos_fabric (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cfg_i  (cfg),
    .data_i (din),
    .data_o (dout)
  );

  // behavioural reference: follow each output back through the three selects
  function automatic logic [31:0] route(logic [19:0] c, logic [31:0] d);
    logic [31:0] r = '0;
    for (int h = 0; h < 2; h++)
      for (int o = 0; o < 2; o++) begin
        int mid = int'(c[12 + (h*2+o)*2 +: 2]);
        if (mid < 3) begin
          int j = int'(c[6 + mid*2 + h]);
          int s = int'(c[j*3 + mid]);
          r[(h*2+o)*8 +: 8] = d[(j*2+s)*8 +: 8];
        end
      end
    return r;
  endfunction

  logic [31:0] p0, p1, p2;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p0 <= '0; p1 <= '0; p2 <= '0;
    end else begin
      p0 <= route(cfg, din); p1 <= p0; p2 <= p1;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (auto_on && rst_n) chk(cur_req, dout, p2);

  task automatic set1(int j, int t, int v); cfg[j*3+t] = v[0]; endtask
  task automatic set2(int t, int h, int v); cfg[6+t*2+h] = v[0]; endtask
  task automatic set3(int h, int o, int v); cfg[12+(h*2+o)*2 +: 2] = v[1:0]; endtask
  task automatic conn(int in_p, int out_p, int mid);
    set1(in_p/2, mid, in_p%2);
    set2(mid, out_p/2, in_p/2);
    set3(out_p/2, out_p%2, mid);
  endtask
  task automatic perm_cfg();
    cfg = '0;
    conn(3, 0, 0); conn(1, 3, 0); conn(0, 1, 1); conn(2, 2, 1);
  endtask
  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    din = 32'h44332211;
    perm_cfg();
    tick(3);
    chk("R1", dout, 32'h0);
    rst_n = 1'b1;                     // released just after a negedge
    tick(1); chk("R1", dout, 32'h0);
    tick(1); chk("R1", dout, 32'h0);
    tick(1); chk("R2", dout, 32'h22331144);
    chk("R8", dout, 32'h22331144);
    auto_on = 1'b1;

    // R10: nothing changes, outputs hold
    held = dout;
    tick(4); chk("R10", dout, held);

    // R2: new data takes exactly three edges
    din = 32'h88776655;
    tick(1); chk("R2", dout, 32'h22331144);
    tick(1); chk("R2", dout, 32'h22331144);
    tick(1); chk("R2", dout, 32'h66775588);

    // R7: input 3 to every output through middle switch 2
    cfg = '0;
    set1(1, 2, 1); set2(2, 0, 1); set2(2, 1, 1);
    for (int k = 0; k < 4; k++) set3(k/2, k%2, 2);
    din = 32'h44332211;
    tick(3); chk("R7", dout, 32'h44444444);

    // R3: ingress field alone moves all outputs to input 1
    cfg = '0; set1(0, 0, 1);
    tick(3); chk("R3", dout, 32'h22222222);

    // R4: middle field picks ingress switch 1 (its node 0 takes input 2)
    cfg = '0; set2(0, 0, 1); set2(0, 1, 1);
    tick(3); chk("R4", dout, 32'h33333333);

    // R5: only output 3 uses middle switch 1, whose ingress node takes input 1
    cfg = '0; set3(1, 1, 1); set1(0, 1, 1);
    tick(3); chk("R5", dout, 32'h22111111);

    // R6: egress select 3 is outside fan-in 3
    perm_cfg(); set3(1, 0, 3);
    tick(3); chk("R6", dout, 32'h22001144);
    set3(0, 0, 3);
    tick(3); chk("R6", dout, 32'h22001100);

    // R9: configuration change while data is in flight
    perm_cfg();
    tick(3); chk("R9", dout, 32'h22331144);
    cfg = '0;
    tick(1); chk("R9", dout, 32'h22331144);
    tick(1); chk("R9", dout, 32'h22331144);
    tick(1); chk("R9", dout, 32'h11111111);

    // random traffic against the model
    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      cfg = 20'($urandom);
      din = $urandom;
      tick(1);
    end
    cur_req = "R8";
    for (int i = 0; i < 50; i++) begin
      perm_cfg();
      din = $urandom;
      tick(1);
    end
    tick(3);
    auto_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule